// File: doc/BRIEF.md
# Stereo Soft Mute Ramp

This block scales a stereo stream of signed 20-bit samples by a gain that moves one step per sample period. A level-sensitive mute request walks the gain from unity down to silence over 1024 sample periods. Dropping the request walks the gain back up to unity over the same number of periods. The ramp advances only when a sample strobe arrives, so its duration in time follows the sample rate.

Left and right samples arrive together with a one-cycle strobe. The scaled pair leaves one clock later with its own strobe. The gain is an integer from 0 to 1024, and each sample is multiplied by gain/1024 with truncation toward zero. A gain of 1024 passes the sample through unchanged, and a gain of 0 gives exact zero. If the mute request changes during a ramp, the ramp turns around from the gain it has reached. It does not jump to either end.

Top module: `smute_ramp`

## Requirements
- R1: After reset, `valid_o` is low, both sample outputs are zero, the gain is unity (1024) and the first sample passes through unchanged.
- R2: For every cycle in which `valid_i` is high, `valid_o` is high in the next cycle and only then, and the scaled samples appear in that same cycle.
- R3: At gain 1024, both outputs equal their inputs bit for bit, including the most positive value (0x7FFFF) and the most negative value (0x80000).
- R4: While `mute_i` is high at a strobe and the gain is above 0, that strobe uses the current gain and lowers the gain by exactly 1 for the next strobe. The 1025th strobe after the mute request uses gain 0.
- R5: At gain 0, both outputs are exactly zero, and they stay zero for every further strobe while mute remains high.
- R6: While `mute_i` is low at a strobe and the gain is below 1024, the gain rises by exactly 1 per strobe and reaches unity 1024 strobes after leaving 0.
- R7: A change of `mute_i` part-way through a ramp reverses direction from the gain reached at that point.
- R8: Each output equals input × gain / 1024 truncated toward zero, for both positive and negative inputs (for example, −1025 at gain 1 gives −1, and −1 at any gain below 1024 gives 0).
- R9: Left and right use the same gain within a strobe.
- R10: `mute_i` is sampled only at strobes. Toggling it between strobes leaves the gain unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mute_i | input | 1 | Mute request, level sensitive, sampled at strobes |
| valid_i | input | 1 | Sample strobe, one per sample period |
| left_i | input | 20 | Left sample, two's complement |
| right_i | input | 20 | Right sample, two's complement |
| valid_o | output | 1 | Output sample strobe, one cycle after valid_i |
| left_o | output | 20 | Scaled left sample |
| right_o | output | 20 | Scaled right sample |

## Verification
Most ramp steps drive the left channel with the most negative code. Because −524288 × g / 1024 is exactly −512·g, the output exposes the gain directly and distinguishes an off-by-one step from a correct one. The right channel carries the most positive code at the same time, which tests truncation of inexact products and confirms that both channels share one gain. Small negative values such as −1 and −1025 at partial gain separate truncation toward zero from flooring. Mute toggles between strobes and a reversal at gain 724 separate sampling at the strobe from free-running behaviour, and show that the ramp turns around from its current value rather than restarting.

// File: rtl/smute_pkg.sv
package smute_pkg;
  typedef enum logic [1:0] {
    RAMP_HOLD = 2'd0,
    RAMP_DOWN = 2'd1,
    RAMP_UP   = 2'd2
  } ramp_dir_e;
endpackage

// File: rtl/smute_gain_ramp.sv
module smute_gain_ramp
  import smute_pkg::*;
#(
  parameter int RAMP_LOG2 = 10,
  localparam int GAIN_W = RAMP_LOG2 + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              mute_i,
  output logic [GAIN_W-1:0] gain_o
);
  localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1 << RAMP_LOG2);

  ramp_dir_e dir;

  always_comb begin
    if (mute_i && gain_o != '0)        dir = RAMP_DOWN;
    else if (!mute_i && gain_o != UNITY) dir = RAMP_UP;
    else                                 dir = RAMP_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gain_o <= UNITY;
    else if (step_i) begin
      case (dir)
        RAMP_DOWN: gain_o <= gain_o - 1'b1;
        RAMP_UP:   gain_o <= gain_o + 1'b1;
        default:   gain_o <= gain_o;
      endcase
    end
  end

  // R4
  down_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && mute_i && gain_o != '0) |=> gain_o == GAIN_W'($past(gain_o) - 1'b1));
  // R6
  up_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !mute_i && gain_o != UNITY) |=> gain_o == GAIN_W'($past(gain_o) + 1'b1));
  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(gain_o));
  // R4
  gain_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_o <= UNITY);
endmodule

// File: rtl/smute_scale.sv
module smute_scale #(
  parameter int DATA_W    = 20,
  parameter int RAMP_LOG2 = 10,
  localparam int GAIN_W = RAMP_LOG2 + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic [GAIN_W-1:0]        gain_i,
  input  logic signed [DATA_W-1:0] smp_i,
  output logic signed [DATA_W-1:0] smp_o
);
  localparam int PROD_W = DATA_W + GAIN_W + 1;
  localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1 << RAMP_LOG2);

  logic signed [PROD_W-1:0] x_ext, g_ext, prod, biased;
  logic signed [DATA_W-1:0] smp_d;

  always_comb begin
    x_ext  = PROD_W'(smp_i);
    g_ext  = PROD_W'({1'b0, gain_i});
    prod   = x_ext * g_ext;
    // bias negatives so the arithmetic shift truncates toward zero
    biased = prod[PROD_W-1] ? prod + PROD_W'((1 << RAMP_LOG2) - 1) : prod;
    smp_d  = DATA_W'(biased >>> RAMP_LOG2);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     smp_o <= '0;
    else if (load_i) smp_o <= smp_d;
  end

  // R5
  silent_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && gain_i == '0) |=> smp_o == '0);
  // R3
  unity_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && gain_i == UNITY) |=> smp_o == $past(smp_i));
  // R2
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(smp_o));
endmodule

// File: rtl/smute_ramp.sv
module smute_ramp #(
  parameter int DATA_W    = 20,
  parameter int RAMP_LOG2 = 10
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     mute_i,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] left_i,
  input  logic signed [DATA_W-1:0] right_i,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] left_o,
  output logic signed [DATA_W-1:0] right_o
);
  localparam int GAIN_W = RAMP_LOG2 + 1;
  localparam int N_CH   = 2;

  logic [GAIN_W-1:0]        gain;
  logic signed [DATA_W-1:0] ch_in  [N_CH];
  logic signed [DATA_W-1:0] ch_out [N_CH];

  assign ch_in[0] = left_i;
  assign ch_in[1] = right_i;
  assign left_o   = ch_out[0];
  assign right_o  = ch_out[1];

  smute_gain_ramp #(.RAMP_LOG2(RAMP_LOG2)) i_gain (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(valid_i),
    .mute_i(mute_i),
    .gain_o(gain)
  );

  // R9: every channel sees the same gain
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    smute_scale #(.DATA_W(DATA_W), .RAMP_LOG2(RAMP_LOG2)) i_scale (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .load_i(valid_i),
      .gain_i(gain),
      .smp_i (ch_in[c]),
      .smp_o (ch_out[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R2
  valid_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R9
  pair_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && left_i == right_i) |=> left_o == right_o);
endmodule

// File: tb/test_smute_ramp.sv
module test_smute_ramp;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mute = 1'b0;
  logic valid = 1'b0;
  logic signed [19:0] l_in = '0, r_in = '0;
  logic valid_o;
  logic signed [19:0] l_out, r_out;

  int checks = 0;
  int errors = 0;
  int g = 1024;
  int cyc = 0;

  always #4 clk = ~clk;

  smute_ramp i_smute_ramp (
    .clk_i(clk), .rst_ni(rst_n), .mute_i(mute), .valid_i(valid),
    .left_i(l_in), .right_i(r_in), .valid_o(valid_o),
    .left_o(l_out), .right_o(r_out)
  );

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: act timeout exp done");
      summary();
      $finish;
    end
  end

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  function automatic logic signed [19:0] scl(int x, int gg);
    longint p = longint'(x) * gg;
    longint q = (p < 0) ? -((-p) / 1024) : p / 1024;
    return 20'(q);
  endfunction

  // send one stereo sample, check result against the model gain, then step model
  task automatic send(int l, int r, string req);
    logic signed [19:0] el, er;
    el = scl(l, g);
    er = scl(r, g);
    @(negedge clk);
    valid = 1'b1; l_in = 20'(l); r_in = 20'(r);
    @(negedge clk);
    valid = 1'b0;
    chk(valid_o === 1'b1, {req, " valid_o"}, longint'(valid_o), 1);
    chk(l_out === el, {req, " left"}, longint'(l_out), longint'(el));
    chk(r_out === er, {req, " right"}, longint'(r_out), longint'(er));
    if (mute && g > 0) g--;
    else if (!mute && g < 1024) g++;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(valid_o === 1'b0, "R1 valid_o", longint'(valid_o), 0);
    chk(l_out === 20'sd0, "R1 left", longint'(l_out), 0);
    chk(r_out === 20'sd0, "R1 right", longint'(r_out), 0);
    send(12345, -54321, "R1");
  endtask

  task automatic t_unity();
    send(524287, -524288, "R3");
    @(negedge clk);
    chk(valid_o === 1'b0, "R2 pulse", longint'(valid_o), 0);
    send(-1, 1, "R3");
    send(0, -7, "R3");
  endtask

  task automatic t_mute_full();
    mute = 1'b1;
    for (int i = 0; i < 1024; i++) send(-524288, 524287, "R4");
    chk(g == 0, "R4 model gain", g, 0);
    for (int i = 0; i < 4; i++) begin
      send(-524288, 524287, "R5");
      chk(l_out === 0 && r_out === 0, "R5 silent", longint'(l_out), 0);
    end
  endtask

  task automatic t_unmute_full();
    mute = 1'b0;
    for (int i = 0; i < 1024; i++) send(-524288, 524287, "R6");
    send(-524288, 524287, "R6 unity");
    chk(l_out === -20'sd524288, "R6 unity left", longint'(l_out), -524288);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      mute = ~mute;
    end
    mute = 1'b0;
    send(-524288, 524287, "R10");
  endtask

  task automatic t_reverse();
    mute = 1'b1;
    for (int i = 0; i < 300; i++) send(-524288, 524287, "R7 down");
    chk(g == 724, "R7 model gain", g, 724);
    mute = 1'b0;
    for (int i = 0; i < 10; i++) send(-524288, 524287, "R7 up");
    mute = 1'b1;
    for (int i = 0; i < 5; i++) send(-524288, 524287, "R7 down2");
  endtask

  task automatic t_round();
    // drive the gain to 1
    mute = 1'b1;
    while (g > 1) send(-524288, 524287, "R8 ramp");
    mute = 1'b0;
    send(-1025, 1025, "R8 g1");
    send(-1, 1, "R8 small");
    send(-3000, 3000, "R9 mirror");
    send(-524287, 77, "R8 mixed");
    chk(g == 5, "R8 model gain", g, 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_unity();
    t_mute_full();
    t_idle();
    t_unmute_full();
    t_reverse();
    t_round();
    summary();
    $finish;
  end
endmodule